// File: doc/BRIEF.md
# Security Code Verifier with Retry Counter

This block decides whether a secure memory may be erased or written. It holds a small security area. Location 0 is a 3-bit retry counter. Locations 1 to 3 are the three bytes of a secret reference code. Commands reach the block already parsed, as an opcode, an address and a data byte. The block answers each command it knows with a one-cycle response that reports pass or fail. The `unlocked` output grants write access to the rest of the memory.

A host unlocks the part by following a fixed procedure:
- Spend one counter bit by writing a value that clears at least one bit of location 0.
- Compare reference bytes 1, 2 and 3, in that order.
- Write 0xFF to location 0 to restore the counter.

Every failed attempt costs one counter bit for good. When the counter reaches zero, the part is blocked forever.

Two inputs start the block again. `por_n` models power-on: it reloads the counter and the factory reference code. `rst_n` is the card reset: it ends a session without restoring anything in storage.

Top module: `sec_code_gate`

## Requirements
- R1: After power-on (`por_n` low), the counter is 3'b111, the reference bytes equal `REF_INIT` (byte 1 in bits 7:0), and `unlocked` is 0.
- R2: Opcode 0x31 always passes. On the cycle of its response, `rd_data` holds the counter in bits 2:0 with bits 7:3 zero. Reference byte k is in bits 8k+7:8k. These reference bytes read as zero while `unlocked` is 0.
- R3: While locked, opcode 0x39 to address 0 only ANDs the counter with data bits 2:0. It passes and arms comparison only if at least one bit is cleared. Otherwise it fails and leaves the counter unchanged.
- R4: A compare (opcode 0x33) that arrives with no armed attempt fails and makes no progress.
- R5: Three armed compares in a row, to addresses 1, 2 and 3 with matching data, each pass. `unlocked` rises with the response to the third compare.
- R6: A compare with wrong data fails. It discards progress and the armed state, and the counter bit that was spent stays cleared.
- R7: A compare to an address other than the next one expected (out of order, skipped, or outside 1 to 3) fails and discards progress.
- R8: When the counter is 0, compares fail, locked counter writes fail, and `unlocked` never rises.
- R9: While unlocked, opcode 0x39 to address 0 loads data bits 2:0 into the counter directly, so 0xFF restores 3'b111. The same opcode to addresses 1 to 3 replaces that reference byte. Both pass.
- R10: While locked, opcode 0x39 to addresses 1 to 3 fails and leaves the reference bytes unchanged.
- R11: `rst_n` low clears `unlocked` and the compare progress, but keeps the counter and the reference bytes.
- R12: Any other opcode produces no response and changes no state.
- R13: `resp_valid` is high for exactly one cycle, the cycle after the clock edge that accepts a known command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; reloads storage |
| rst_n | input | 1 | Session reset, active low, asynchronous; storage kept |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 8 | Opcode: 0x31 read, 0x33 compare, 0x39 update |
| cmd_addr | input | ADDR_W | Security address |
| cmd_data | input | DATA_W | Data byte for compare or update |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_fail | output | 1 | Response reports a failure |
| rd_data | output | (REF_N+1)*DATA_W | Security image returned by a read |
| unlocked | output | 1 | Erase and write access granted |

## Verification
Every result is registered once. A command held over one rising edge therefore shows its `resp_valid`, `resp_fail`, `rd_data` and any change of `unlocked` in the cycle that follows, and `resp_valid` drops one cycle later. The bench drives each command on a falling edge and withdraws it on the next falling edge. It samples the outputs at that second falling edge, half a cycle after they settle. The effects of resets, writes and ignored opcodes are observed later through read commands.

// File: rtl/sec_code_gate.sv
module sec_code_gate #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 3,
  parameter int REF_N  = 3,
  parameter logic [REF_N*DATA_W-1:0] REF_INIT = 24'h5AC3F1
) (
  input  logic                          clk,
  input  logic                          por_n,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic [7:0]                    cmd_op,
  input  logic [ADDR_W-1:0]             cmd_addr,
  input  logic [DATA_W-1:0]             cmd_data,
  output logic                          resp_valid,
  output logic                          resp_fail,
  output logic [(REF_N+1)*DATA_W-1:0]   rd_data,
  output logic                          unlocked
);
  localparam logic [7:0] OP_READ = 8'h31;
  localparam logic [7:0] OP_CMP  = 8'h33;
  localparam logic [7:0] OP_UPD  = 8'h39;
  localparam int PW    = $clog2(REF_N + 1);
  localparam int IMG_W = (REF_N + 1) * DATA_W;

  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] ref_q [REF_N];
  logic              verified, armed;
  logic [PW-1:0]     prog;
  logic              sess_rst_n;
  logic              is_read, is_cmp, is_upd, known;
  logic              at_cnt, at_ref, cnt_live, last_byte;
  logic [DATA_W-1:0] ref_sel;
  logic [CNT_W-1:0]  cnt_and;
  logic              cmp_ok, upd_ok;
  logic [IMG_W-1:0]  image;

  assign sess_rst_n = por_n & rst_n;
  assign is_read    = cmd_valid && (cmd_op == OP_READ);
  assign is_cmp     = cmd_valid && (cmd_op == OP_CMP);
  assign is_upd     = cmd_valid && (cmd_op == OP_UPD);
  assign known      = is_read || is_cmp || is_upd;
  assign at_cnt     = (cmd_addr == '0);
  assign at_ref     = (cmd_addr >= ADDR_W'(1)) && (cmd_addr <= ADDR_W'(REF_N));
  assign cnt_live   = (cnt != '0);
  assign cnt_and    = cnt & cmd_data[CNT_W-1:0];
  assign last_byte  = (prog == PW'(REF_N - 1));

  always_comb begin
    ref_sel = '0;
    for (int i = 0; i < REF_N; i++)
      if (cmd_addr == ADDR_W'(i + 1)) ref_sel = ref_q[i];
  end

  assign cmp_ok = armed && cnt_live && at_ref &&
                  (cmd_addr == ADDR_W'(prog) + ADDR_W'(1)) &&
                  (cmd_data == ref_sel);

  assign upd_ok = verified ? (at_cnt || at_ref)
                           : (at_cnt && cnt_live && (cnt_and != cnt));

  always_comb begin
    image = '0;
    image[CNT_W-1:0] = cnt;
    for (int i = 0; i < REF_N; i++)
      image[(i+1)*DATA_W +: DATA_W] = verified ? ref_q[i] : '0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt <= '1;
      for (int i = 0; i < REF_N; i++) ref_q[i] <= REF_INIT[i*DATA_W +: DATA_W];
    end else if (is_upd && upd_ok) begin
      if (at_cnt) cnt <= verified ? cmd_data[CNT_W-1:0] : cnt_and;
      for (int i = 0; i < REF_N; i++)
        if (cmd_addr == ADDR_W'(i + 1)) ref_q[i] <= cmd_data;
    end
  end

  always_ff @(posedge clk or negedge sess_rst_n) begin
    if (!sess_rst_n) begin
      verified   <= 1'b0;
      armed      <= 1'b0;
      prog       <= '0;
      resp_valid <= 1'b0;
      resp_fail  <= 1'b0;
      rd_data    <= '0;
    end else begin
      resp_valid <= known;
      resp_fail  <= known && !(is_read || (is_cmp && cmp_ok) || (is_upd && upd_ok));
      if (is_read) rd_data <= image;
      if (is_upd && upd_ok && at_cnt && !verified) begin
        armed <= 1'b1;
        prog  <= '0;
      end
      if (is_cmp) begin
        if (cmp_ok && !last_byte) prog <= prog + PW'(1);
        else begin
          prog  <= '0;
          armed <= 1'b0;
        end
        if (cmp_ok && last_byte) verified <= 1'b1;
      end
    end
  end

  assign unlocked = verified;

  assert_cnt_no_gain_R3: assert property (@(posedge clk) disable iff (!sess_rst_n)
    !verified |=> ((cnt & ~$past(cnt)) == '0));

  assert_no_unlock_empty_R8: assert property (@(posedge clk) disable iff (!sess_rst_n)
    $rose(verified) |-> ($past(cnt) != '0));

  assert_unlock_after_compare_R5: assert property (@(posedge clk) disable iff (!sess_rst_n)
    $rose(verified) |-> $past(is_cmp));

  assert_hidden_refs_R2: assert property (@(posedge clk) disable iff (!sess_rst_n)
    (is_read && !verified) |=> (rd_data[IMG_W-1:DATA_W] == '0));

  assert_resp_follows_R13: assert property (@(posedge clk) disable iff (!sess_rst_n)
    known |=> resp_valid);

  assert_no_stray_resp_R12: assert property (@(posedge clk) disable iff (!sess_rst_n)
    !known |=> !resp_valid && !resp_fail);
endmodule

// File: tb/sec_code_gate_bench.sv
`timescale 1ns/1ps
module sec_code_gate_bench;
  logic        clk = 1'b0;
  logic        por_n, rst_n, cmd_valid;
  logic [7:0]  cmd_op, cmd_addr, cmd_data;
  logic        resp_valid, resp_fail, unlocked;
  logic [31:0] rd_data;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sec_code_gate u_sec_code_gate (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .resp_valid(resp_valid), .resp_fail(resp_fail), .rd_data(rd_data),
    .unlocked(unlocked));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send(logic [7:0] op, logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic issue(logic [7:0] op, logic [7:0] a, logic [7:0] d, bit exp_fail, string tag);
    send(op, a, d);
    chk({tag, " resp_valid"}, 32'(resp_valid), 32'd1);
    chk({tag, " resp_fail"}, 32'(resp_fail), 32'(exp_fail));
  endtask

  task automatic read_chk(logic [31:0] exp, string tag);
    send(8'h31, 8'h00, 8'h00);
    chk({tag, " rd_data"}, rd_data, exp);
  endtask

  task automatic power_cycle();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
  endtask

  task automatic t_power_on();
    chk("R1 unlocked after power-on", 32'(unlocked), 32'd0);
    chk("R1 no response after power-on", 32'(resp_valid), 32'd0);
    read_chk(32'h0000_0007, "R1 R2 power-on image");
    @(negedge clk);
    chk("R13 resp_valid one cycle only", 32'(resp_valid), 32'd0);
  endtask

  task automatic t_unarmed();
    issue(8'h33, 8'd1, 8'hF1, 1, "R4 compare without spent bit");
    issue(8'h33, 8'd2, 8'hC3, 1, "R4 second unarmed compare");
    chk("R4 still locked", 32'(unlocked), 32'd0);
  endtask

  task automatic t_spend();
    issue(8'h39, 8'd0, 8'hFE, 0, "R3 spend bit 0");
    read_chk(32'h0000_0006, "R3 counter after spend");
    issue(8'h39, 8'd0, 8'hFF, 1, "R3 write clearing nothing");
    issue(8'h39, 8'd1, 8'h00, 1, "R10 locked reference write");
    read_chk(32'h0000_0006, "R3 counter unchanged");
  endtask

  task automatic t_mismatch();
    issue(8'h33, 8'd1, 8'hF1, 0, "R6 first byte matches");
    issue(8'h33, 8'd2, 8'h00, 1, "R6 wrong second byte");
    issue(8'h33, 8'd3, 8'h5A, 1, "R6 progress discarded");
    read_chk(32'h0000_0006, "R6 spent bit stays cleared");
    chk("R6 locked", 32'(unlocked), 32'd0);
  endtask

  task automatic t_order();
    issue(8'h39, 8'd0, 8'hFD, 0, "R3 spend bit 1");
    issue(8'h33, 8'd1, 8'hF1, 0, "R7 first byte");
    issue(8'h33, 8'd3, 8'h5A, 1, "R7 skipped byte 2");
    issue(8'h33, 8'd2, 8'hC3, 1, "R7 progress gone after skip");
    chk("R7 locked", 32'(unlocked), 32'd0);
  endtask

  task automatic t_session_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    read_chk(32'h0000_0004, "R11 counter kept over reset");
    chk("R11 locked after reset", 32'(unlocked), 32'd0);
  endtask

  task automatic t_unlock();
    power_cycle();
    read_chk(32'h0000_0007, "R1 counter restored by power-on");
    issue(8'h39, 8'd0, 8'hFE, 0, "R5 spend");
    issue(8'h33, 8'd1, 8'hF1, 0, "R5 byte 1");
    issue(8'h33, 8'd2, 8'hC3, 0, "R5 byte 2");
    chk("R5 not yet unlocked", 32'(unlocked), 32'd0);
    issue(8'h33, 8'd3, 8'h5A, 0, "R5 byte 3");
    chk("R5 unlocked", 32'(unlocked), 32'd1);
    read_chk(32'h5AC3_F106, "R2 R10 references visible");
    issue(8'h39, 8'd0, 8'hFF, 0, "R9 restore counter");
    read_chk(32'h5AC3_F107, "R9 counter restored");
    issue(8'h39, 8'd2, 8'h77, 0, "R9 rewrite reference 2");
    issue(8'h39, 8'd0, 8'h02, 0, "R9 direct counter load");
    read_chk(32'h5A77_F102, "R9 new image");
    issue(8'h39, 8'd0, 8'hFF, 0, "R9 restore again");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R11 reset revokes access", 32'(unlocked), 32'd0);
    read_chk(32'h0000_0007, "R11 R2 hidden after reset");
  endtask

  task automatic t_other_ops();
    send(8'h30, 8'd0, 8'h00);
    chk("R12 no response to other opcode", 32'(resp_valid), 32'd0);
    send(8'h38, 8'd0, 8'h00);
    chk("R12 no response to 0x38", 32'(resp_valid), 32'd0);
    read_chk(32'h0000_0007, "R12 counter untouched");
  endtask

  task automatic t_exhaust();
    issue(8'h39, 8'd0, 8'hFE, 0, "R8 spend 1");
    issue(8'h33, 8'd1, 8'h00, 1, "R8 wrong 1");
    issue(8'h39, 8'd0, 8'hFD, 0, "R8 spend 2");
    issue(8'h33, 8'd1, 8'h00, 1, "R8 wrong 2");
    issue(8'h39, 8'd0, 8'hFB, 0, "R8 spend last");
    issue(8'h33, 8'd1, 8'hF1, 1, "R8 compare blocked");
    issue(8'h39, 8'd0, 8'h00, 1, "R8 write blocked");
    read_chk(32'h0000_0000, "R8 counter empty");
    chk("R8 locked forever", 32'(unlocked), 32'd0);
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0; cmd_valid = 1'b0;
    cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    t_power_on();
    t_unarmed();
    t_spend();
    t_mismatch();
    t_order();
    t_session_reset();
    t_unlock();
    t_other_ops();
    t_exhaust();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule